// File: doc/BRIEF.md
# Tag-Checking Execution Unit

This unit performs the arithmetic, logic and shift step for a machine whose 40-bit words carry their own type. Each word is split into two parts. The upper 8 bits are the tag: a 6-bit type code in bits 39:34 and a 2-bit reference-count hint in bits 33:32. The lower 32 bits are the data field. Type code 1 marks a small integer and type code 2 marks a pointer. Only the 6-bit type code takes part in the checks.

A request is issued by pulsing `start_i` with an operation code and two operands. In the same cycle, the unit checks the operand types against the operation and computes the 32-bit result. One clock later it reports exactly one of two outcomes:

- a valid result, tagged as a small integer; or
- a trap, with a cause code. When a trap is reported, the result register keeps its previous contents.

Signed overflow on add or subtract is also reported as a trap. It has its own cause code.

Top module: `tagged_exec_unit`

## Requirements
- R1: After reset, `result_o` is 0 and `valid_o`, `trap_o` and `cause_o` are all 0.
- R2: Opcodes 0 (add) and 1 (subtract) with two small-integer operands produce the 32-bit two's-complement sum or difference of the data fields. The result is presented with `valid_o` high in the cycle after `start_i` is sampled.
- R3: If an add or subtract with two small-integer operands overflows as a signed 32-bit operation, the unit raises `trap_o` with cause 2 instead of `valid_o`.
- R4: If an add or subtract has an operand whose type code is not 1, the unit raises `trap_o` with cause 1. This cause takes precedence over overflow.
- R5: Opcodes 2 (AND), 3 (OR) and 4 (XOR) require only operand A to be a small integer. Operand B may be of any type. If operand A is not a small integer, the unit traps with cause 1.
- R6: Opcodes 5 (shift left logical), 6 (shift right logical) and 7 (shift right arithmetic) shift operand A's data field by the amount in operand B bits 4:0. Operand A must be a small integer, otherwise the unit traps with cause 1.
- R7: The reference-count bits 33:32 of the operands do not affect the type check. Every valid result carries tag byte 0x04, meaning type 1 with the count bits cleared.
- R8: A trap leaves `result_o` holding its previous value.
- R9: `valid_o` and `trap_o` are never high together. Each is a one-cycle pulse, and both stay low in any cycle not preceded by a sampled `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe; operands and opcode are sampled with it |
| op_i | input | 3 | Operation code (0..7, see R2, R5, R6) |
| opa_i | input | 40 | Operand A, tagged word |
| opb_i | input | 40 | Operand B, tagged word |
| result_o | output | 40 | Registered tagged result |
| valid_o | output | 1 | One-cycle strobe: `result_o` holds a new result |
| trap_o | output | 1 | One-cycle strobe: the request was rejected |
| cause_o | output | 2 | Trap cause: 0 none, 1 wrong type, 2 overflow |

## Verification
The add and subtract path is tried in four ways, and each one separates a different fault:

- Ordinary values show that the correct operation is selected.
- Values exactly at the signed limits separate an overflow detector built on the carry from a correct sign-based one.
- A pointer placed in each operand position in turn shows that both tags are inspected.
- A pointer combined with overflowing data shows the priority between the two causes.

Logic operations are run with a pointer as operand B to show that B's type is ignored. Shift amounts above 31 in operand B show that only bits 4:0 are used, and a negative operand A separates logical from arithmetic right shifts. Operands with non-zero count bits show that only the type code is compared. A trap that follows a valid result shows that the previous result is held.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_SRA = 3'd7
    } exu_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TYPE = 2'd1,
        CAUSE_OVF  = 2'd2
    } trap_cause_e;

    function automatic logic op_is_arith(input exu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/exu_tag_check.sv
module exu_tag_check
    import exu_pkg::*;
#(
    parameter int TYPE_W   = 6,
    parameter int INT_CODE = 1
) (
    input  exu_op_e           op_i,
    input  logic [TYPE_W-1:0] type_a_i,
    input  logic [TYPE_W-1:0] type_b_i,
    output logic              type_ok_o
);

    localparam logic [TYPE_W-1:0] IntCode = TYPE_W'(INT_CODE);

    logic a_int, b_int;

    always_comb begin
        a_int = (type_a_i == IntCode);
        b_int = (type_b_i == IntCode);
        // arithmetic needs both operands integer; logic and shift only operand A
        if (op_is_arith(op_i)) type_ok_o = a_int && b_int;
        else                   type_ok_o = a_int;
    end

endmodule

// File: rtl/exu_data_alu.sv
module exu_data_alu
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  exu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o
);

    localparam int SH_W = $clog2(DATA_W);
    localparam int MSB  = DATA_W - 1;

    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] sum, diff;

    always_comb begin
        sh_amt = b_i[SH_W-1:0];
        sum    = a_i + b_i;
        diff   = a_i - b_i;
        ovf_o  = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                res_o = sum;
                ovf_o = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
            end
            OP_SUB: begin
                res_o = diff;
                ovf_o = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
            end
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_SHL:  res_o = a_i << sh_amt;
            OP_SHR:  res_o = a_i >> sh_amt;
            OP_SRA:  res_o = DATA_W'($signed(a_i) >>> sh_amt);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/tagged_exec_unit.sv
module tagged_exec_unit
    import exu_pkg::*;
#(
    parameter int WORD_W   = 40,
    parameter int DATA_W   = 32,
    parameter int TYPE_W   = 6,
    parameter int INT_CODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic [WORD_W-1:0] result_o,
    output logic              valid_o,
    output logic              trap_o,
    output logic [1:0]        cause_o
);

    localparam int TAG_W = WORD_W - DATA_W;
    localparam int RC_W  = TAG_W - TYPE_W;
    localparam logic [TAG_W-1:0] IntTag = {TYPE_W'(INT_CODE), {RC_W{1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              valid;
        logic              trap;
        trap_cause_e       cause;
    } exu_state_t;

    exu_state_t        st_d, st_q;
    exu_op_e           op;
    logic              type_ok, ovf;
    logic [DATA_W-1:0] alu_res;

    assign op = exu_op_e'(op_i);

    exu_tag_check #(.TYPE_W(TYPE_W), .INT_CODE(INT_CODE)) i_tag_check (
        .op_i      (op),
        .type_a_i  (opa_i[WORD_W-1 -: TYPE_W]),
        .type_b_i  (opb_i[WORD_W-1 -: TYPE_W]),
        .type_ok_o (type_ok)
    );

    exu_data_alu #(.DATA_W(DATA_W)) i_data_alu (
        .op_i  (op),
        .a_i   (opa_i[DATA_W-1:0]),
        .b_i   (opb_i[DATA_W-1:0]),
        .res_o (alu_res),
        .ovf_o (ovf)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.trap  = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (start_i) begin
            if (!type_ok) begin
                st_d.trap  = 1'b1;
                st_d.cause = CAUSE_TYPE;
            end else if (ovf && op_is_arith(op)) begin
                st_d.trap  = 1'b1;
                st_d.cause = CAUSE_OVF;
            end else begin
                st_d.valid  = 1'b1;
                st_d.result = {IntTag, alu_res};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign valid_o  = st_q.valid;
    assign trap_o   = st_q.trap;
    assign cause_o  = st_q.cause;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && trap_o));

    a_r9_no_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o && !trap_o);

    a_r8_trap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !type_ok |=> trap_o && $stable(result_o));

    a_r7_result_tag: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> result_o[WORD_W-1 -: TAG_W] == IntTag);

    a_r3_add_sign: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op == OP_ADD && opa_i[DATA_W-1] == opb_i[DATA_W-1]
        |=> !valid_o || result_o[DATA_W-1] == $past(opa_i[DATA_W-1]));

    a_r4_ovf_only_arith: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !op_is_arith(op) |=> cause_o != CAUSE_OVF);

endmodule

// File: tb/test_tagged_exec_unit.sv
module test_tagged_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  op_i;
    logic [39:0] opa_i, opb_i;
    logic [39:0] result_o;
    logic        valid_o, trap_o;
    logic [1:0]  cause_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    tagged_exec_unit i_tagged_exec_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .result_o (result_o),
        .valid_o  (valid_o),
        .trap_o   (trap_o),
        .cause_o  (cause_o)
    );

    function automatic logic [39:0] word(input logic [5:0] ty, input logic [1:0] rc,
                                         input logic [31:0] d);
        return {ty, rc, d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issues one request; returns with the registered outcome visible.
    task automatic issue(input logic [2:0] op, input logic [39:0] a, input logic [39:0] b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [31:0] d);
        check(req, {62'd0, valid_o, trap_o}, 64'd2);
        check(req, {24'd0, result_o}, {24'd0, 8'h04, d});
    endtask

    task automatic expect_trap(input string req, input logic [1:0] cause,
                               input logic [39:0] prev);
        check(req, {62'd0, valid_o, trap_o}, 64'd1);
        check(req, {62'd0, cause_o}, {62'd0, cause});
        check(req, {24'd0, result_o}, {24'd0, prev});
    endtask

    task automatic t_reset;
        check("R1", {22'd0, result_o, valid_o, trap_o}, 64'd0);
        check("R1", {62'd0, cause_o}, 64'd0);
    endtask

    task automatic t_arith;
        issue(3'd0, word(6'h01, 2'd0, 32'd5), word(6'h01, 2'd0, 32'd7));
        expect_ok("R2", 32'd12);
        issue(3'd1, word(6'h01, 2'd0, 32'd3), word(6'h01, 2'd0, 32'd5));
        expect_ok("R2", 32'hFFFF_FFFE);
        issue(3'd0, word(6'h01, 2'd0, 32'hFFFF_FFFF), word(6'h01, 2'd0, 32'd1));
        expect_ok("R2", 32'd0);
    endtask

    task automatic t_overflow;
        logic [39:0] prev;
        prev = result_o;
        issue(3'd0, word(6'h01, 2'd0, 32'h7FFF_FFFF), word(6'h01, 2'd0, 32'd1));
        expect_trap("R3", 2'd2, prev);
        issue(3'd1, word(6'h01, 2'd0, 32'h8000_0000), word(6'h01, 2'd0, 32'd1));
        expect_trap("R3", 2'd2, prev);
        issue(3'd1, word(6'h01, 2'd0, 32'h7FFF_FFFE), word(6'h01, 2'd0, 32'hFFFF_FFFF));
        expect_ok("R3", 32'h7FFF_FFFF);
    endtask

    task automatic t_wrong_type;
        logic [39:0] prev;
        prev = result_o;
        issue(3'd0, word(6'h02, 2'd0, 32'd1), word(6'h01, 2'd0, 32'd1));
        expect_trap("R4", 2'd1, prev);
        issue(3'd1, word(6'h01, 2'd0, 32'd1), word(6'h02, 2'd0, 32'd1));
        expect_trap("R4", 2'd1, prev);
        issue(3'd0, word(6'h02, 2'd0, 32'h7FFF_FFFF), word(6'h01, 2'd0, 32'd1));
        expect_trap("R4", 2'd1, prev);
    endtask

    task automatic t_logic;
        issue(3'd2, word(6'h01, 2'd0, 32'h0000_F0F0), word(6'h02, 2'd0, 32'h0000_FF00));
        expect_ok("R5", 32'h0000_F000);
        issue(3'd3, word(6'h01, 2'd0, 32'h0000_F0F0), word(6'h02, 2'd0, 32'h0000_FF00));
        expect_ok("R5", 32'h0000_FFF0);
        issue(3'd4, word(6'h01, 2'd0, 32'h0000_F0F0), word(6'h01, 2'd0, 32'h0000_FF00));
        expect_ok("R5", 32'h0000_0FF0);
        issue(3'd4, word(6'h02, 2'd0, 32'd1), word(6'h01, 2'd0, 32'd1));
        expect_trap("R5", 2'd1, {8'h04, 32'h0000_0FF0});
    endtask

    task automatic t_shift;
        issue(3'd5, word(6'h01, 2'd0, 32'd1), word(6'h01, 2'd0, 32'd31));
        expect_ok("R6", 32'h8000_0000);
        issue(3'd6, word(6'h01, 2'd0, 32'h8000_0000), word(6'h01, 2'd0, 32'd4));
        expect_ok("R6", 32'h0800_0000);
        issue(3'd7, word(6'h01, 2'd0, 32'h8000_0000), word(6'h01, 2'd0, 32'd4));
        expect_ok("R6", 32'hF800_0000);
        issue(3'd5, word(6'h01, 2'd0, 32'd3), word(6'h01, 2'd0, 32'h25));
        expect_ok("R6", 32'd96);
        issue(3'd6, word(6'h03, 2'd0, 32'd3), word(6'h01, 2'd0, 32'd1));
        expect_trap("R6", 2'd1, {8'h04, 32'd96});
    endtask

    task automatic t_refcount;
        issue(3'd0, word(6'h01, 2'd3, 32'd10), word(6'h01, 2'd2, 32'd20));
        expect_ok("R7", 32'd30);
        issue(3'd2, word(6'h01, 2'd1, 32'hFF), word(6'h02, 2'd3, 32'h0F));
        expect_ok("R7", 32'h0F);
    endtask

    task automatic t_hold_and_pulse;
        issue(3'd0, word(6'h01, 2'd0, 32'd100), word(6'h01, 2'd0, 32'd1));
        expect_ok("R8", 32'd101);
        issue(3'd0, word(6'h02, 2'd0, 32'd1), word(6'h01, 2'd0, 32'd1));
        expect_trap("R8", 2'd1, {8'h04, 32'd101});
        @(negedge clk);
        check("R9", {62'd0, valid_o, trap_o}, 64'd0);
        check("R9", {62'd0, cause_o}, 64'd0);
        check("R8", {24'd0, result_o}, {24'd0, 8'h04, 32'd101});
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith();
        t_overflow();
        t_wrong_type();
        t_logic();
        t_shift();
        t_refcount();
        t_hold_and_pulse();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule